// File: doc/BRIEF.md
# DRAM ECC Error Capture Unit

This block sits next to the ECC checker of a DRAM controller and records what that checker reports. Each cycle the checker may flag a correctable (single-bit) or an uncorrectable (multi-bit) event. It also presents the 64-bit data word, the stored check byte and the address of the access. The block keeps a sticky flag for each kind of event and captures the details of the first one. Correctable events can be thinned out by a programmable count threshold. The block drives one interrupt line, gated by a per-source enable.

The same register file holds a per-source disable mask. It also holds three injection registers whose contents go straight out to the write path, so faults can be forced into stored data. Software reaches all of this through a plain 32-bit word-addressed register bus. Writes are single-cycle strobes and reads are combinational.

Top module: `ddr_ecc_err_capture`

## Requirements
- R1: After reset the detect, disable, enable and injection registers read zero, the threshold field reads 1 with a count of 0, and `irq` is low.
- R2: An enabled uncorrectable event sets detect bit 3, which reads back after the clock edge at which the event was sampled.
- R3: Word 3 holds the correctable-event threshold in bits 23:16 and the running count in bits 7:0. Each enabled correctable event raises the count. The event that brings the count to the threshold sets detect bit 2 and returns the count to 0. Writing word 3 loads the threshold and clears the count. A threshold of 0 behaves as a threshold of 1.
- R4: Detect (word 0) is write-one-to-clear: a 1 in bit 3 or bit 2 clears that flag, and a 0 leaves it alone. When an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R5: Disable (word 1) bit 3 blocks uncorrectable events and bit 2 blocks correctable ones. A blocked event sets no flag, does not change the count and captures nothing.
- R6: A flag-setting event that arrives while detect reads zero loads the capture words. Data high goes to word 4, data low to word 5, the check byte to word 6 bits 7:0, address bits 31:0 to word 7 and the upper address bits to word 8. While any flag is set the capture words hold their values.
- R7: `irq` is high exactly when some detect bit is set whose enable bit is also set in word 2 (bit 3 uncorrectable, bit 2 correctable).
- R8: Injection words 9 (data high mask), 10 (data low mask) and 11 (control, bits 8:0 kept) read back what was written. `inj_data_mask` is {word 9, word 10}, `inj_en` is word 11 bit 8 and `inj_chk_mask` is word 11 bits 7:0.
- R9: `reg_rdata` follows `reg_addr` in the same cycle, and unmapped words 12 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_sbe | input | 1 | Correctable event from the ECC checker |
| ev_mbe | input | 1 | Uncorrectable event from the ECC checker |
| ev_data | input | 64 | Data word of the failing access |
| ev_chk | input | 8 | Check byte of the failing access |
| ev_addr | input | ADDR_W | Address of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Error interrupt |
| inj_data_mask | output | 64 | Data XOR mask for injection |
| inj_chk_mask | output | 8 | Check byte XOR mask for injection |
| inj_en | output | 1 | Injection enable |

## Verification
Events and register writes take effect at the edge that samples them. Detect, count, capture and `irq` are therefore readable in the cycle right after that edge, and read data is combinational on the index. The bench drives a stimulus just after a rising edge and lets the following edge register it. It then places the read index after that edge and compares at the falling edge. Each expected value is queued by the driver before the monitor compares it at that falling edge, so no result is sampled before the edge that produces it.

// File: rtl/ddr_ecc_err_capture.sv
module ddr_ecc_err_capture #(
  parameter int ADDR_W = 36,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sbe,
  input  logic              ev_mbe,
  input  logic [63:0]       ev_data,
  input  logic [7:0]        ev_chk,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [63:0]       inj_data_mask,
  output logic [7:0]        inj_chk_mask,
  output logic              inj_en
);
  localparam logic [3:0] A_DET = 4'd0, A_DIS = 4'd1, A_IEN = 4'd2, A_SBM = 4'd3,
                         A_CDH = 4'd4, A_CDL = 4'd5, A_CCK = 4'd6, A_CAL = 4'd7,
                         A_CAH = 4'd8, A_IJH = 4'd9, A_IJL = 4'd10, A_IJC = 4'd11;
  localparam int THR_LSB = 16;

  // flag vectors: [1] = uncorrectable (bit 3), [0] = correctable (bit 2)
  logic [1:0]       det, dis, ien;
  logic [THR_W-1:0] thr, cnt;
  logic [63:0]      cap_data, cap_addr;
  logic [7:0]       cap_chk;
  logic [31:0]      ij_hi, ij_lo;
  logic [8:0]       ij_ctl;

  wire              wr_det  = reg_wr && reg_addr == A_DET;
  wire              wr_sbm  = reg_wr && reg_addr == A_SBM;
  wire [1:0]        clr     = wr_det ? reg_wdata[3:2] : 2'b00;
  wire              sbe_hit = ev_sbe && !dis[0];
  wire              mbe_hit = ev_mbe && !dis[1];
  wire [THR_W:0]    cnt_nx  = {1'b0, cnt} + 1'b1;
  wire              sbe_set = sbe_hit && (cnt_nx >= {1'b0, thr});
  wire [1:0]        set     = {mbe_hit, sbe_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det <= '0; dis <= '0; ien <= '0;
      thr <= THR_W'(1); cnt <= '0;
      cap_data <= '0; cap_addr <= '0; cap_chk <= '0;
      ij_hi <= '0; ij_lo <= '0; ij_ctl <= '0;
    end else begin
      det <= (det & ~clr) | set;
      if (|set && det == 2'b00) begin
        cap_data <= ev_data;
        cap_chk  <= ev_chk;
        cap_addr <= 64'(ev_addr);
      end
      if (wr_sbm) begin
        thr <= reg_wdata[THR_LSB +: THR_W];
        cnt <= '0;
      end else if (sbe_hit) begin
        cnt <= sbe_set ? '0 : cnt_nx[THR_W-1:0];
      end
      if (reg_wr) begin
        case (reg_addr)
          A_DIS:   dis    <= reg_wdata[3:2];
          A_IEN:   ien    <= reg_wdata[3:2];
          A_IJH:   ij_hi  <= reg_wdata;
          A_IJL:   ij_lo  <= reg_wdata;
          A_IJC:   ij_ctl <= reg_wdata[8:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_DET:   reg_rdata = {28'd0, det, 2'b00};
      A_DIS:   reg_rdata = {28'd0, dis, 2'b00};
      A_IEN:   reg_rdata = {28'd0, ien, 2'b00};
      A_SBM:   reg_rdata = 32'({thr, {(THR_LSB-THR_W){1'b0}}, cnt});
      A_CDH:   reg_rdata = cap_data[63:32];
      A_CDL:   reg_rdata = cap_data[31:0];
      A_CCK:   reg_rdata = {24'd0, cap_chk};
      A_CAL:   reg_rdata = cap_addr[31:0];
      A_CAH:   reg_rdata = cap_addr[63:32];
      A_IJH:   reg_rdata = ij_hi;
      A_IJL:   reg_rdata = ij_lo;
      A_IJC:   reg_rdata = {23'd0, ij_ctl};
      default: reg_rdata = '0;
    endcase
  end

  assign irq           = |(det & ien);
  assign inj_data_mask = {ij_hi, ij_lo};
  assign inj_en        = ij_ctl[8];
  assign inj_chk_mask  = ij_ctl[7:0];

  AST_MBE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mbe && !dis[1]) |=> det[1]); // R2
  AST_CNT_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0) |-> (cnt < thr)); // R3
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sbe && !dis[0] && thr == THR_W'(1) && !wr_sbm) |=> det[0]); // R4
  AST_DIS_BLOCKS_MBE: assert property (@(posedge clk) disable iff (!rst_n)
    (dis[1] && !det[1]) |=> !det[1]); // R5
  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (det != 2'b00) |=> ($stable(cap_data) && $stable(cap_addr) && $stable(cap_chk))); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq); // R7
endmodule

// File: tb/ddr_ecc_err_capture_tb.sv
module ddr_ecc_err_capture_tb;
  localparam time CLK = 10ns;
  localparam int  AW  = 36;

  logic clk = 0, rst_n = 0;
  logic ev_sbe = 0, ev_mbe = 0;
  logic [63:0] ev_data = '0;
  logic [7:0]  ev_chk = '0;
  logic [AW-1:0] ev_addr = '0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, inj_en;
  logic [63:0] inj_data_mask;
  logic [7:0] inj_chk_mask;

  ddr_ecc_err_capture #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe), .ev_data(ev_data),
    .ev_chk(ev_chk), .ev_addr(ev_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .inj_data_mask(inj_data_mask), .inj_chk_mask(inj_chk_mask), .inj_en(inj_en));

  always #(CLK/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, mon_req = 0;
  int          q_kind[$];
  logic [31:0] q_val[$];
  string       q_tag[$];

  // monitor: kind 0 = register read, 1 = irq, 2 = {inj_en, inj_chk_mask}, 3 = inj_data_mask high
  always @(negedge clk) begin
    if (mon_req) begin
      int k; logic [31:0] e, a; string t;
      k = q_kind.pop_front(); e = q_val.pop_front(); t = q_tag.pop_front();
      case (k)
        0: a = reg_rdata;
        1: a = {31'd0, irq};
        2: a = {23'd0, inj_en, inj_chk_mask};
        default: a = inj_data_mask[63:32];
      endcase
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
      mon_req = 0;
    end
  end

  task automatic expect_at(int kind, logic [3:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    reg_addr = a;
    q_kind.push_back(kind); q_val.push_back(e); q_tag.push_back(tag);
    mon_req = 1;
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic ev(bit s, bit m, logic [63:0] d, logic [7:0] c, logic [AW-1:0] ad);
    @(posedge clk); #1;
    ev_sbe = s; ev_mbe = m; ev_data = d; ev_chk = c; ev_addr = ad;
    @(posedge clk); #1;
    ev_sbe = 0; ev_mbe = 0;
  endtask

  initial begin
    #(CLK*150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_at(0, 4'd0, 32'h0, "R1 detect");
    expect_at(0, 4'd1, 32'h0, "R1 disable");
    expect_at(0, 4'd2, 32'h0, "R1 enable");
    expect_at(0, 4'd3, 32'h0001_0000, "R1 threshold");
    expect_at(0, 4'd11, 32'h0, "R1 inject ctrl");
    expect_at(1, 4'd0, 32'h0, "R1 irq");
    // R8 injection, R9 unmapped
    wr(4'd9, 32'hDEAD_BEEF);
    wr(4'd10, 32'h1234_5678);
    wr(4'd11, 32'hFFFF_FFFF);
    expect_at(0, 4'd9, 32'hDEAD_BEEF, "R8 inj hi");
    expect_at(0, 4'd10, 32'h1234_5678, "R8 inj lo");
    expect_at(0, 4'd11, 32'h0000_01FF, "R8 inj ctrl");
    expect_at(2, 4'd0, 32'h0000_01FF, "R8 inj outputs");
    expect_at(3, 4'd0, 32'hDEAD_BEEF, "R8 inj mask out");
    expect_at(0, 4'd13, 32'h0, "R9 unmapped");
    // R2 / R6 first uncorrectable event
    ev(0, 1, 64'hAAAA_5555_0F0F_F0F0, 8'h5C, 36'h9_1234_5678);
    expect_at(0, 4'd0, 32'h8, "R2 mbe flag");
    expect_at(0, 4'd4, 32'hAAAA_5555, "R6 data hi");
    expect_at(0, 4'd5, 32'h0F0F_F0F0, "R6 data lo");
    expect_at(0, 4'd6, 32'h5C, "R6 chk");
    expect_at(0, 4'd7, 32'h1234_5678, "R6 addr lo");
    expect_at(0, 4'd8, 32'h9, "R6 addr ext");
    // R7 interrupt gating
    expect_at(1, 4'd0, 32'h0, "R7 irq masked");
    wr(4'd2, 32'h8);
    expect_at(1, 4'd0, 32'h1, "R7 irq mbe");
    wr(4'd2, 32'h4);
    expect_at(1, 4'd0, 32'h0, "R7 irq wrong source");
    // R6 frozen
    ev(0, 1, 64'h1111_2222_3333_4444, 8'h01, 36'h0_0000_0040);
    expect_at(0, 4'd5, 32'h0F0F_F0F0, "R6 frozen lo");
    // R4 write-one-to-clear
    wr(4'd0, 32'h4);
    expect_at(0, 4'd0, 32'h8, "R4 other bit kept");
    wr(4'd0, 32'h8);
    expect_at(0, 4'd0, 32'h0, "R4 cleared");
    // R3 threshold three
    wr(4'd3, 32'h0003_0000);
    ev(1, 0, 64'h0, 8'h0, '0);
    ev(1, 0, 64'h0, 8'h0, '0);
    expect_at(0, 4'd0, 32'h0, "R3 below threshold");
    expect_at(0, 4'd3, 32'h0003_0002, "R3 count");
    ev(1, 0, 64'hCAFE_0000_0000_BABE, 8'h33, 36'h0_0000_1000);
    expect_at(0, 4'd0, 32'h4, "R3 threshold reached");
    expect_at(0, 4'd3, 32'h0003_0000, "R3 count reset");
    expect_at(0, 4'd5, 32'h0000_BABE, "R6 sbe capture");
    expect_at(1, 4'd0, 32'h1, "R7 irq sbe");
    wr(4'd0, 32'hFFFF_FFFF);
    expect_at(0, 4'd0, 32'h0, "R4 clear all");
    // R5 disable
    wr(4'd1, 32'hC);
    ev(1, 1, 64'h7777_7777_7777_7777, 8'h77, '0);
    expect_at(0, 4'd0, 32'h0, "R5 blocked flags");
    expect_at(0, 4'd3, 32'h0003_0000, "R5 count untouched");
    expect_at(0, 4'd5, 32'h0000_BABE, "R5 no capture");
    wr(4'd1, 32'h0);
    // R4 set beats clear in same cycle
    @(posedge clk); #1;
    ev_mbe = 1; reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h8;
    @(posedge clk); #1;
    ev_mbe = 0; reg_wr = 0;
    expect_at(0, 4'd0, 32'h8, "R4 set wins");
    wr(4'd0, 32'hF);
    // R3 threshold zero acts as one
    wr(4'd3, 32'h0);
    ev(1, 0, 64'h0, 8'h0, '0);
    expect_at(0, 4'd0, 32'h4, "R3 threshold zero");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule